// File: doc/BRIEF.md
# Framebuffer Pixel Word Formatter

This block sits between the memory fetch path of a display controller and its parallel LCD data bus. It accepts 32-bit memory words over a valid/ready handshake and emits one pixel per handshake on a 24-bit output. Each pixel is right-aligned, so the same port serves panels wired for 16, 18 or 24 data lines. Two configuration inputs select how words are unpacked. The word length code picks 16 or 32 bits per pixel. The bus width code picks the number of data lines the panel uses.

For 16 bits per pixel, each word carries two RGB565 pixels. The lower halfword leaves first and the upper halfword second. For 32 bits per pixel, each word carries one pixel and its top byte is discarded. On a 24-line bus the pixel keeps its full 8-bit components. On a 16- or 18-line bus the top two bits of each component byte are dropped, which leaves 6 bits per component. Unsupported combinations raise a configuration error and stop the stream.

The block also contains a separate combinational helper that packs three 16-bit channel values into a pixel word in one of three field layouts. It can first replace all three channels with a fixed-point luminance value. A FIFO-clear input throws away any word that has been only partly sent.

Top module: `pxfmt_top`

## Requirements
- R1: Word length code 0 selects 16 bits per pixel and code 3 selects 32 bits per pixel. Codes 1 and 2 raise `cfg_error`, hold `out_valid` and `in_ready` low, and accept no word even when `in_valid` is high.
- R2: Word length code 3 together with bus width code 0 (8-bit bus) raises `cfg_error` and produces no output. The other bus codes (1 = 16-bit, 2 = 18-bit, 3 = 24-bit) are legal with either word length.
- R3: `byte_mask` is 4'hF in 16-bit mode, 4'h7 in legal 32-bit mode, and 4'h0 whenever `cfg_error` is high.
- R4: In 16-bit mode, each accepted word yields two pixels. The first is `{8'h00, word[15:0]}` and the second is `{8'h00, word[31:16]}`. Each halfword is RGB565, with red in bits 15:11, green in bits 10:5 and blue in bits 4:0.
- R5: In 32-bit mode on a 24-bit bus, each word yields one pixel equal to `word[23:0]`, with red in 23:16, green in 15:8 and blue in 7:0. Bits 31:24 have no effect.
- R6: In 32-bit mode on a 16- or 18-bit bus, each word yields `{6'b0, word[21:16], word[13:8], word[5:0]}`. Bits 31:22, 15:14 and 7:6 have no effect.
- R7: A word is taken on a clock edge where `in_valid` and `in_ready` are both high. Its first pixel is presented with `out_valid` high right after that edge. While `out_ready` is low, `out_valid` and `out_pixel` hold steady and `in_ready` is low. After reset, `out_valid` is 0 and `in_ready` is 1.
- R8: While `fifo_clr` is high, `in_ready` is low. After a cycle with `fifo_clr` high, `out_valid` is 0, any unsent half of a word is lost, and the next accepted word starts again from its lower halfword.
- R9: The packer places the top N bits of each 16-bit channel at a field offset and ORs the three fields together. Format 0 places red 5@11, green 6@5 and blue 5@0. Format 1 places red 6@16, green 6@8 and blue 6@0. Format 2 places red 8@16, green 8@8 and blue 8@0. Format 3 yields zero.
- R10: With `pk_grey` high, the packer first replaces each of red, green and blue by (19595*R + 38470*G + 7471*B) >> 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word_len | input | 2 | Word length code (0 = 16 bpp, 3 = 32 bpp) |
| cfg_bus_width | input | 2 | Bus width code (0 = 8, 1 = 16, 2 = 18, 3 = 24 lines) |
| fifo_clr | input | 1 | Drop buffered word and reset halfword selector |
| in_valid | input | 1 | Memory word valid |
| in_data | input | 32 | Memory word |
| in_ready | output | 1 | Word can be accepted |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Pixel sink ready |
| out_pixel | output | 24 | Right-aligned pixel |
| cfg_error | output | 1 | Illegal configuration |
| byte_mask | output | 4 | Bytes of each word that carry pixel data |
| pk_grey | input | 1 | Packer: convert to luminance first |
| pk_fmt | input | 2 | Packer: field layout code |
| pk_red | input | 16 | Packer: red channel |
| pk_green | input | 16 | Packer: green channel |
| pk_blue | input | 16 | Packer: blue channel |
| pk_word | output | 32 | Packer: packed word |

## Verification
A word accepted on one edge shows its first pixel right after that edge, with no added register stage. In 16-bit mode the second halfword follows one pixel handshake later. Configuration decode, the error flag, the byte mask and the packer output are all combinational and settle within the same cycle as their inputs. The bench therefore changes inputs on the falling edge and samples 1 ns later. At that point each pixel about to be taken on the next rising edge is compared against a queue of expected values, which the driver fills when it offers the word.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;

  typedef enum logic [1:0] {
    MODE_HALF   = 2'd0,
    MODE_FULL24 = 2'd1,
    MODE_RED18  = 2'd2,
    MODE_BAD    = 2'd3
  } pmode_e;

  typedef enum logic [1:0] {
    FMT_565  = 2'd0,
    FMT_666  = 2'd1,
    FMT_888  = 2'd2,
    FMT_NONE = 2'd3
  } pfmt_e;

  typedef struct packed {
    logic [4:0] len;
    logic [4:0] off;
  } fld_t;

  localparam logic [1:0] WL_16 = 2'd0;
  localparam logic [1:0] WL_32 = 2'd3;
  localparam logic [1:0] BUS_8 = 2'd0;

  // channel index: 0 red, 1 green, 2 blue
  function automatic fld_t fld_of(pfmt_e f, int unsigned ch);
    fld_t r;
    r.len = 5'd0;
    r.off = 5'd0;
    case (f)
      FMT_565: begin
        r.len = (ch == 1) ? 5'd6 : 5'd5;
        r.off = (ch == 0) ? 5'd11 : ((ch == 1) ? 5'd5 : 5'd0);
      end
      FMT_666: begin
        r.len = 5'd6;
        r.off = (ch == 0) ? 5'd16 : ((ch == 1) ? 5'd8 : 5'd0);
      end
      FMT_888: begin
        r.len = 5'd8;
        r.off = (ch == 0) ? 5'd16 : ((ch == 1) ? 5'd8 : 5'd0);
      end
      default: begin
        r.len = 5'd0;
        r.off = 5'd0;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pxfmt_cfg_dec.sv
module pxfmt_cfg_dec
  import pxfmt_pkg::*;
(
  input  logic [1:0] word_len,
  input  logic [1:0] bus_w,
  output pmode_e     mode,
  output logic       err,
  output logic [3:0] mask
);

  always_comb begin
    mode = MODE_BAD;
    if (word_len == WL_16) begin
      mode = MODE_HALF;
    end else if (word_len == WL_32) begin
      if (bus_w == BUS_8)       mode = MODE_BAD;
      else if (bus_w == 2'd3)   mode = MODE_FULL24;
      else                      mode = MODE_RED18;
    end
  end

  always_comb begin
    err  = 1'b0;
    mask = 4'h0;
    case (mode)
      MODE_HALF:   mask = 4'hF;
      MODE_FULL24: mask = 4'h7;
      MODE_RED18:  mask = 4'h7;
      default: begin
        err  = 1'b1;
        mask = 4'h0;
      end
    endcase
  end

endmodule

// File: rtl/pxfmt_unpack.sv
module pxfmt_unpack
  import pxfmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PIX_W  = 24,
  parameter int CMP_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pmode_e            mode,
  input  logic              fifo_clr,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pixel
);

  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = 8;
  localparam int RED_W  = 3 * CMP_W;

  logic [DATA_W-1:0] word_q;
  logic              have_q, have_d;
  logic              hi_q, hi_d;
  logic              mode_ok, last_pix, out_fire, in_fire;

  assign mode_ok   = (mode != MODE_BAD);
  assign last_pix  = (mode != MODE_HALF) || hi_q;
  assign out_valid = have_q && mode_ok;
  assign out_fire  = out_valid && out_ready;
  assign in_ready  = mode_ok && !fifo_clr && (!have_q || (out_ready && last_pix));
  assign in_fire   = in_valid && in_ready;

  // next state
  always_comb begin
    have_d = have_q;
    hi_d   = hi_q;
    if (fifo_clr) begin
      have_d = 1'b0;
      hi_d   = 1'b0;
    end else begin
      if (out_fire) begin
        if (last_pix) begin
          have_d = 1'b0;
          hi_d   = 1'b0;
        end else begin
          hi_d = 1'b1;
        end
      end
      if (in_fire) begin
        have_d = 1'b1;
        hi_d   = 1'b0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      have_q <= have_d;
      hi_q   <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (in_fire) begin
      word_q <= in_data;
    end
  end

  // pixel selection
  logic [HALF_W-1:0] half_sel;
  logic [RED_W-1:0]  reduced;

  assign half_sel = hi_q ? word_q[DATA_W-1:HALF_W] : word_q[HALF_W-1:0];

  generate
    for (genvar c = 0; c < 3; c++) begin : g_red
      assign reduced[c*CMP_W +: CMP_W] = word_q[c*BYTE_W +: CMP_W];
    end
  endgenerate

  always_comb begin
    out_pixel = '0;
    case (mode)
      MODE_HALF:   out_pixel = PIX_W'(half_sel);
      MODE_FULL24: out_pixel = word_q[PIX_W-1:0];
      MODE_RED18:  out_pixel = PIX_W'(reduced);
      default:     out_pixel = '0;
    endcase
  end

endmodule

// File: rtl/pxfmt_field_pack.sv
module pxfmt_field_pack
  import pxfmt_pkg::*;
#(
  parameter int CH_W   = 16,
  parameter int WORD_W = 32
) (
  input  logic              grey,
  input  pfmt_e             fmt,
  input  logic [CH_W-1:0]   red,
  input  logic [CH_W-1:0]   green,
  input  logic [CH_W-1:0]   blue,
  output logic [WORD_W-1:0] word
);

  localparam int ACC_W = 2 * CH_W + 2;
  localparam int FRAC  = 16;
  localparam logic [ACC_W-1:0] K_R = ACC_W'(19595);
  localparam logic [ACC_W-1:0] K_G = ACC_W'(38470);
  localparam logic [ACC_W-1:0] K_B = ACC_W'(7471);

  logic [ACC_W-1:0] acc;
  logic [CH_W-1:0]  luma;
  logic [CH_W-1:0]  chan [3];
  logic [WORD_W-1:0] part [3];

  assign acc  = ACC_W'(red) * K_R + ACC_W'(green) * K_G + ACC_W'(blue) * K_B;
  assign luma = CH_W'(acc >> FRAC);

  assign chan[0] = grey ? luma : red;
  assign chan[1] = grey ? luma : green;
  assign chan[2] = grey ? luma : blue;

  generate
    for (genvar i = 0; i < 3; i++) begin : g_ch
      fld_t f;
      assign f = fld_of(fmt, i);
      assign part[i] = (WORD_W'(chan[i]) >> (CH_W - int'(f.len))) << f.off;
    end
  endgenerate

  always_comb begin
    word = '0;
    for (int i = 0; i < 3; i++) word = word | part[i];
  end

endmodule

// File: rtl/pxfmt_top.sv
module pxfmt_top
  import pxfmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_word_len,
  input  logic [1:0]  cfg_bus_width,
  input  logic        fifo_clr,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [23:0] out_pixel,
  output logic        cfg_error,
  output logic [3:0]  byte_mask,
  input  logic        pk_grey,
  input  logic [1:0]  pk_fmt,
  input  logic [15:0] pk_red,
  input  logic [15:0] pk_green,
  input  logic [15:0] pk_blue,
  output logic [31:0] pk_word
);

  pmode_e mode;

  pxfmt_cfg_dec u_dec (
    .word_len (cfg_word_len),
    .bus_w    (cfg_bus_width),
    .mode     (mode),
    .err      (cfg_error),
    .mask     (byte_mask)
  );

  pxfmt_unpack #(.DATA_W(32), .PIX_W(24), .CMP_W(6)) u_unp (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .fifo_clr  (fifo_clr),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pixel (out_pixel)
  );

  pxfmt_field_pack #(.CH_W(16), .WORD_W(32)) u_pack (
    .grey  (pk_grey),
    .fmt   (pfmt_e'(pk_fmt)),
    .red   (pk_red),
    .green (pk_green),
    .blue  (pk_blue),
    .word  (pk_word)
  );

endmodule

// File: rtl/pxfmt_chk.sv
module pxfmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cfg_word_len,
  input logic [1:0]  cfg_bus_width,
  input logic        fifo_clr,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_pixel,
  input logic        cfg_error,
  input logic [3:0]  byte_mask,
  input logic        pk_grey,
  input logic [1:0]  pk_fmt,
  input logic [31:0] pk_word
);

  p_error_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> (!out_valid && !in_ready));

  p_narrow_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word_len == 2'd3 && cfg_bus_width == 2'd0) |-> cfg_error);

  p_mask16_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word_len == 2'd0) |-> (byte_mask == 4'hF));

  p_mask32_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word_len == 2'd3 && !cfg_error) |-> (byte_mask == 4'h7));

  p_half_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_word_len == 2'd0) |-> (out_pixel[23:16] == 8'h00));

  p_reduced_top_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_word_len == 2'd3 && (cfg_bus_width == 2'd1 || cfg_bus_width == 2'd2))
      |-> (out_pixel[23:18] == 6'd0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !fifo_clr) |=> (out_valid && $stable(out_pixel)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> !out_valid);

  p_grey_equal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_grey && pk_fmt == 2'd2) |-> (pk_word[23:16] == pk_word[15:8] && pk_word[15:8] == pk_word[7:0]));

endmodule

bind pxfmt_top pxfmt_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_word_len  (cfg_word_len),
  .cfg_bus_width (cfg_bus_width),
  .fifo_clr      (fifo_clr),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_pixel     (out_pixel),
  .cfg_error     (cfg_error),
  .byte_mask     (byte_mask),
  .pk_grey       (pk_grey),
  .pk_fmt        (pk_fmt),
  .pk_word       (pk_word)
);

// File: tb/pxfmt_top_tb_top.sv
module pxfmt_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic [1:0]  cfg_word_len;
  logic [1:0]  cfg_bus_width;
  logic        fifo_clr;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready;
  logic [23:0] out_pixel;
  logic        cfg_error;
  logic [3:0]  byte_mask;
  logic        pk_grey;
  logic [1:0]  pk_fmt;
  logic [15:0] pk_red, pk_green, pk_blue;
  logic [31:0] pk_word;

  logic thr, tog, rdy_man, done;
  int   n_chk, n_fail;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  assign out_ready = thr ? tog : rdy_man;

  pxfmt_top dut_i (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) tog <= ~tog;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares pixels that will be taken on the next rising edge
  always begin
    @(negedge clk);
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R7 unexpected pixel actual=%h expected=none", out_pixel);
      end else begin
        check(tag_q.pop_front(), 32'(out_pixel), 32'(exp_q.pop_front()));
      end
    end
  end

  task automatic expect_px(input string req, input logic [23:0] v);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  task automatic push_word(input logic [31:0] w);
    if (cfg_word_len == 2'd0) begin
      expect_px("R4 low half", {8'h00, w[15:0]});
      expect_px("R4 high half", {8'h00, w[31:16]});
    end else if (cfg_bus_width == 2'd3) begin
      expect_px("R5 full24", w[23:0]);
    end else begin
      expect_px("R6 reduced18", {6'd0, w[21:16], w[13:8], w[5:0]});
    end
  endtask

  // called just after a falling edge
  task automatic send(input logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200; i++) begin
      if (exp_q.size() == 0 && !out_valid) break;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    check("R7 drained", 32'(exp_q.size()), 32'd0);
  endtask

  function automatic logic [31:0] pack_exp(input logic grey, input logic [1:0] fmt,
                                           input logic [15:0] r, input logic [15:0] g,
                                           input logic [15:0] b);
    longint unsigned y;
    logic [15:0] c [3];
    int len [3];
    int off [3];
    logic [31:0] res;
    y = (64'(r) * 19595 + 64'(g) * 38470 + 64'(b) * 7471) >> 16;
    c[0] = grey ? 16'(y) : r;
    c[1] = grey ? 16'(y) : g;
    c[2] = grey ? 16'(y) : b;
    case (fmt)
      2'd0: begin len = '{5, 6, 5}; off = '{11, 5, 0}; end
      2'd1: begin len = '{6, 6, 6}; off = '{16, 8, 0}; end
      2'd2: begin len = '{8, 8, 8}; off = '{16, 8, 0}; end
      default: begin len = '{0, 0, 0}; off = '{0, 0, 0}; end
    endcase
    res = 32'd0;
    for (int i = 0; i < 3; i++)
      if (len[i] != 0) res |= (32'(c[i]) >> (16 - len[i])) << off[i];
    return res;
  endfunction

  task automatic pk_try(input logic grey, input logic [1:0] fmt,
                        input logic [15:0] r, input logic [15:0] g, input logic [15:0] b);
    @(negedge clk);
    pk_grey = grey; pk_fmt = fmt; pk_red = r; pk_green = g; pk_blue = b;
    #1;
    check(grey ? "R10 grey pack" : "R9 field pack", pk_word, pack_exp(grey, fmt, r, g, b));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0;
    tog = 1'b0; thr = 1'b0; rdy_man = 1'b1;
    rst_n = 1'b0; fifo_clr = 1'b0; in_valid = 1'b0; in_data = '0;
    cfg_word_len = 2'd0; cfg_bus_width = 2'd3;
    pk_grey = 1'b0; pk_fmt = 2'd0; pk_red = '0; pk_green = '0; pk_blue = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R7 reset out_valid", 32'(out_valid), 32'd0);
    check("R7 reset in_ready", 32'(in_ready), 32'd1);
    check("R3 mask 16bpp", 32'(byte_mask), 32'hF);
    @(negedge clk);

    // R4: 16 bpp, sink always ready, then throttled
    push_word(32'hABCD_1234); send(32'hABCD_1234);
    push_word(32'h0001_FFFF); send(32'h0001_FFFF);
    push_word(32'h8000_7FFF); send(32'h8000_7FFF);
    drain();
    thr = 1'b1;
    push_word(32'hF800_07E0); send(32'hF800_07E0);
    push_word(32'h001F_5A5A); send(32'h001F_5A5A);
    drain();
    thr = 1'b0;

    // R5: 32 bpp on 24-bit bus, top byte ignored
    cfg_word_len = 2'd3; cfg_bus_width = 2'd3;
    #1;
    check("R3 mask 32bpp", 32'(byte_mask), 32'h7);
    check("R2 bus24 legal", 32'(cfg_error), 32'd0);
    @(negedge clk);
    push_word(32'hFF12_3456); send(32'hFF12_3456);
    push_word(32'h00AB_CDEF); send(32'h00AB_CDEF);
    drain();

    // R6: 32 bpp on 18- and 16-bit bus
    cfg_bus_width = 2'd2;
    @(negedge clk);
    push_word(32'hFFFF_FFFF); send(32'hFFFF_FFFF);
    push_word(32'hC0C0_C0C0); send(32'hC0C0_C0C0);
    drain();
    cfg_bus_width = 2'd1;
    @(negedge clk);
    thr = 1'b1;
    push_word(32'h0035_2A15); send(32'h0035_2A15);
    push_word(32'h7F80_41BE); send(32'h7F80_41BE);
    drain();
    thr = 1'b0;

    // R7: stall holds pixel, blocks input
    cfg_bus_width = 2'd3;
    rdy_man = 1'b0;
    @(negedge clk);
    push_word(32'h0012_3456); send(32'h0012_3456);
    repeat (3) @(negedge clk);
    #1;
    check("R7 stall valid", 32'(out_valid), 32'd1);
    check("R7 stall pixel", 32'(out_pixel), 32'h12_3456);
    check("R7 stall in_ready", 32'(in_ready), 32'd0);
    @(negedge clk);
    rdy_man = 1'b1;
    drain();

    // R8: clear drops the unsent high half
    cfg_word_len = 2'd0;
    rdy_man = 1'b0;
    @(negedge clk);
    send(32'hDEAD_BEEF);
    expect_px("R8 low half before clear", 24'h00_BEEF);
    rdy_man = 1'b1;
    @(negedge clk);
    rdy_man = 1'b0;
    fifo_clr = 1'b1;
    #1;
    check("R8 in_ready during clear", 32'(in_ready), 32'd0);
    @(negedge clk);
    fifo_clr = 1'b0;
    #1;
    check("R8 valid after clear", 32'(out_valid), 32'd0);
    @(negedge clk);
    rdy_man = 1'b1;
    push_word(32'h1111_2222); send(32'h1111_2222);
    drain();

    // R1: unsupported word lengths
    cfg_word_len = 2'd1;
    #1;
    check("R1 code1 error", 32'(cfg_error), 32'd1);
    check("R3 mask on error", 32'(byte_mask), 32'h0);
    in_valid = 1'b1; in_data = 32'hCAFE_F00D;
    #1;
    check("R1 code1 in_ready", 32'(in_ready), 32'd0);
    check("R1 code1 out_valid", 32'(out_valid), 32'd0);
    repeat (4) @(negedge clk);
    cfg_word_len = 2'd2;
    #1;
    check("R1 code2 error", 32'(cfg_error), 32'd1);
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    cfg_word_len = 2'd0;
    #1;
    check("R1 nothing captured", 32'(out_valid), 32'd0);
    @(negedge clk);

    // R2: 32 bpp with 8-bit bus
    cfg_word_len = 2'd3; cfg_bus_width = 2'd0;
    in_valid = 1'b1; in_data = 32'h0055_AA55;
    #1;
    check("R2 error", 32'(cfg_error), 32'd1);
    check("R2 in_ready", 32'(in_ready), 32'd0);
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    cfg_bus_width = 2'd3;
    #1;
    check("R2 nothing captured", 32'(out_valid), 32'd0);
    cfg_word_len = 2'd0;
    #1;
    check("R2 bus8 legal at 16bpp", 32'(cfg_error), 32'd0);

    // R9 / R10: packer
    pk_try(1'b0, 2'd0, 16'hFFFF, 16'h0000, 16'hFFFF);
    pk_try(1'b0, 2'd0, 16'h8421, 16'hC3C3, 16'h1234);
    pk_try(1'b0, 2'd1, 16'hABCD, 16'h5678, 16'hFC00);
    pk_try(1'b0, 2'd2, 16'h1234, 16'hABCD, 16'hFF00);
    pk_try(1'b0, 2'd3, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    pk_try(1'b1, 2'd2, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    pk_try(1'b1, 2'd0, 16'hFFFF, 16'h0000, 16'h0000);
    pk_try(1'b1, 2'd1, 16'h1000, 16'h8000, 16'h4000);
    pk_try(1'b1, 2'd2, 16'h0000, 16'h0000, 16'hFFFF);

    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule